// File: doc/BRIEF.md
# Masked Bit Test-and-Modify Unit

This unit takes a 16-bit word that has already been fetched, together with an 8-bit mask, a half select and an operation code. The half select places the mask over the upper or the lower byte of the word. The unit then tests the masked bits. Two of the operations also write back a modified word: one sets the masked bits and one clears them. Each result carries a condition flag, the result word and a write-enable. The consumer uses the write-enable to decide whether to store the word back.

Operands enter through a valid/ready stream and results leave through another. There is one register stage. When the consumer raises `out_ready`, one operand can be accepted on every cycle. While a result is held with `out_ready` low, `in_ready` is low, and the held result stays stable until it is taken. An input transfers only in a cycle where `in_valid` and `in_ready` are both high. An output transfers only in a cycle where `out_valid` and `out_ready` are both high.

Top module: `bit_tm_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `out_valid` and `out_wr_en` are low and `in_ready` is high.
- R2: Operation code 2'b00 tests for low. `out_flag` is 1 exactly when every masked bit of the input word is 0.
- R3: Operation code 2'b01 tests for high. `out_flag` is 1 exactly when every masked bit of the input word is 1.
- R4: Operation code 2'b10 tests for high and then sets. `out_flag` follows the R3 rule on the word before it is changed, and every masked bit of `out_data` is 1.
- R5: Operation code 2'b11 tests for low and then clears. `out_flag` follows the R2 rule on the word before it is changed, and every masked bit of `out_data` is 0.
- R6: With `in_hi`=1, mask bit i covers data bit 8+i. With `in_hi`=0, mask bit i covers data bit i.
- R7: Data bits outside the placed mask reach `out_data` unchanged. For codes 2'b00 and 2'b01, `out_data` equals the input word.
- R8: `out_wr_en` is high only while `out_valid` is high and the result came from code 2'b10 or 2'b11. It is low for every result from code 2'b00 or 2'b01.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid`, `out_data`, `out_flag` and `out_wr_en` hold their values.
- R10: An all-zero mask makes `out_flag` 1 for every code and leaves the word unchanged.
- R11: An accepted operand gives its result with `out_valid` high on the next cycle. With `out_ready` held high, back-to-back operands come out one per cycle in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Unit can take an operand |
| in_data | input | 16 | Word to test |
| in_mask | input | 8 | Bit mask |
| in_hi | input | 1 | 1: mask over bits 15:8; 0: mask over bits 7:0 |
| in_op | input | 2 | 00 test low, 01 test high, 10 test high and set, 11 test low and clear |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 16 | Result word |
| out_wr_en | output | 1 | Result word should be written back |
| out_flag | output | 1 | Test condition met (1) or not (0) |

## Verification
The test and the modification happen in the same cycle, so the flag could wrongly be taken from the modified word. The bench provokes this with set and clear operations on words whose masked bits are only partly set. It then checks that the flag reports the original word while `out_data` shows the fully modified bits. Acceptance of a new operand and holding a stalled result can also fall in the same cycle. The bench provokes this by lowering `out_ready` with a second operand already waiting. It judges the case by `in_ready`, by the held output, and by the result order once the stall is released.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  typedef enum logic [1:0] {
    OP_TEST_LO = 2'b00,
    OP_TEST_HI = 2'b01,
    OP_SET_HI  = 2'b10,
    OP_CLR_LO  = 2'b11
  } bmu_op_e;
endpackage

// File: rtl/bmu_mask_place.sv
// Spreads the narrow mask over the selected segment of the data word.
module bmu_mask_place #(
  parameter int DW = 16,
  parameter int MW = 8
) (
  input  logic [MW-1:0] mask,
  input  logic          hi,
  output logic [DW-1:0] full
);
  localparam int NSEG = DW / MW;

  for (genvar seg = 0; seg < NSEG; seg++) begin : g_seg
    localparam bit IS_TOP = (seg == NSEG - 1);
    localparam bit IS_BOT = (seg == 0);
    assign full[seg*MW +: MW] = ((hi && IS_TOP) || (!hi && IS_BOT)) ? mask : '0;
  end
endmodule

// File: rtl/bmu_eval.sv
// Evaluates the test on the original word and forms the modified word.
module bmu_eval
  import bmu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] fmask,
  input  bmu_op_e       op,
  output logic [DW-1:0] res,
  output logic          flag,
  output logic          wr
);
  logic all_ones;
  logic all_zeros;

  assign all_ones  = &(data | ~fmask);
  assign all_zeros = ~|(data & fmask);

  always_comb begin
    res  = data;
    flag = 1'b0;
    wr   = 1'b0;
    unique case (op)
      OP_TEST_LO: flag = all_zeros;
      OP_TEST_HI: flag = all_ones;
      OP_SET_HI: begin
        flag = all_ones;
        res  = data | fmask;
        wr   = 1'b1;
      end
      OP_CLR_LO: begin
        flag = all_zeros;
        res  = data & ~fmask;
        wr   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bmu_out_stage.sv
// Single register slice with valid/ready flow control.
module bmu_out_stage #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic          s_flag,
  input  logic          s_wr,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data,
  output logic          m_flag,
  output logic          m_wr
);
  logic          vld_q;
  logic [DW-1:0] data_q;
  logic          flag_q;
  logic          wr_q;

  assign s_ready = !vld_q || m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      flag_q <= 1'b0;
      wr_q   <= 1'b0;
    end else if (s_ready) begin
      vld_q <= s_valid;
      if (s_valid) begin
        data_q <= s_data;
        flag_q <= s_flag;
        wr_q   <= s_wr;
      end
    end
  end

  assign m_valid = vld_q;
  assign m_data  = data_q;
  assign m_flag  = flag_q;
  assign m_wr    = wr_q && vld_q;
endmodule

// File: rtl/bit_tm_unit.sv
module bit_tm_unit
  import bmu_pkg::*;
#(
  parameter int DW = 16,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic [MW-1:0] in_mask,
  input  logic          in_hi,
  input  logic [1:0]    in_op,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_wr_en,
  output logic          out_flag
);
  logic [DW-1:0] fmask;
  logic [DW-1:0] ev_res;
  logic          ev_flag;
  logic          ev_wr;
  bmu_op_e       op_e;

  assign op_e = bmu_op_e'(in_op);

  bmu_mask_place #(.DW(DW), .MW(MW)) u_place (
    .mask (in_mask),
    .hi   (in_hi),
    .full (fmask)
  );

  bmu_eval #(.DW(DW)) u_eval (
    .data  (in_data),
    .fmask (fmask),
    .op    (op_e),
    .res   (ev_res),
    .flag  (ev_flag),
    .wr    (ev_wr)
  );

  bmu_out_stage #(.DW(DW)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (ev_res),
    .s_flag  (ev_flag),
    .s_wr    (ev_wr),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (out_data),
    .m_flag  (out_flag),
    .m_wr    (out_wr_en)
  );
endmodule

// File: rtl/bmu_chk.sv
module bmu_chk #(
  parameter int DW = 16,
  parameter int MW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_data,
  input logic [MW-1:0] in_mask,
  input logic          in_hi,
  input logic [1:0]    in_op,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_wr_en,
  input logic          out_flag
);
  logic [DW-1:0] pmask;
  assign pmask = {{(DW-MW){1'b0}}, in_mask} << (in_hi ? (DW - MW) : 0);

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_wr_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr_en |-> out_valid);

  p_test_nowr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_op[1]) |=> !out_wr_en);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_flag) && $stable(out_wr_en)));

  p_stall_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (((out_data ^ $past(in_data)) & ~$past(pmask)) == '0));
endmodule

bind bit_tm_unit bmu_chk #(.DW(DW), .MW(MW)) u_chk (.*);

// File: tb/test_bit_tm_unit.sv
`timescale 1ns/1ps
module test_bit_tm_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_hi, out_valid, out_ready, out_wr_en, out_flag;
  logic [15:0] in_data, out_data;
  logic [7:0]  in_mask;
  logic [1:0]  in_op;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bit_tm_unit i_bit_tm_unit (.*);

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Reference built from the requirement text.
  task automatic model(input logic [15:0] d, input logic [7:0] m, input logic hi,
                       input logic [1:0] op, output logic [15:0] rd,
                       output logic f, output logic w);
    logic ones = 1'b1;
    logic zeros = 1'b1;
    rd = d;
    for (int i = 0; i < 16; i++) begin
      logic sel;
      sel = hi ? (i >= 8 && m[i-8]) : (i < 8 && m[i]);
      if (sel) begin
        if (d[i]) zeros = 1'b0; else ones = 1'b0;
        if (op == 2'b10) rd[i] = 1'b1;
        if (op == 2'b11) rd[i] = 1'b0;
      end
    end
    f = (op == 2'b01 || op == 2'b10) ? ones : zeros;
    w = op[1];
  endtask

  task automatic drive(logic [15:0] d, logic [7:0] m, logic hi, logic [1:0] op);
    in_valid = 1'b1; in_data = d; in_mask = m; in_hi = hi; in_op = op;
  endtask

  task automatic check_out(string req, logic [15:0] d, logic [7:0] m, logic hi,
                           logic [1:0] op);
    logic [15:0] rd; logic f, w;
    model(d, m, hi, op, rd, f, w);
    chk({req, " valid"}, 16'(out_valid), 16'd1);
    chk({req, " data"}, out_data, rd);
    chk({req, " flag"}, 16'(out_flag), 16'(f));
    chk({req, " wr"}, 16'(out_wr_en), 16'(w));
  endtask

  task automatic one_op(string req, logic [15:0] d, logic [7:0] m, logic hi,
                        logic [1:0] op);
    @(negedge clk);
    out_ready = 1'b1;
    drive(d, m, hi, op);
    @(negedge clk);
    in_valid = 1'b0;
    check_out(req, d, m, hi, op);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_data = '0; in_mask = '0; in_hi = 1'b0; in_op = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid", 16'(out_valid), 16'd0);
    chk("R1 wr", 16'(out_wr_en), 16'd0);
    chk("R1 ready", 16'(in_ready), 16'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post valid", 16'(out_valid), 16'd0);
  endtask

  task automatic t_tests();
    one_op("R2 pass", 16'hFF00, 8'hF0, 1'b0, 2'b00);
    one_op("R2 fail", 16'hFF10, 8'hF0, 1'b0, 2'b00);
    one_op("R3 pass", 16'h00F3, 8'h03, 1'b0, 2'b01);
    one_op("R3 fail", 16'h00F1, 8'h03, 1'b0, 2'b01);
    one_op("R7 test passthru", 16'hA5C3, 8'h5A, 1'b1, 2'b01);
  endtask

  task automatic t_modify();
    // Partly set masked bits: flag must show the word before the change.
    one_op("R4 partial", 16'h1234, 8'h0F, 1'b0, 2'b10);
    one_op("R4 already", 16'h12FF, 8'h0F, 1'b0, 2'b10);
    one_op("R5 partial", 16'h1234, 8'hF0, 1'b0, 2'b11);
    one_op("R5 already", 16'h1204, 8'hF0, 1'b0, 2'b11);
  endtask

  task automatic t_half();
    one_op("R6 hi set", 16'h0000, 8'h81, 1'b1, 2'b10);
    chk("R6 hi bits", out_data, 16'h8100);
    one_op("R6 lo clr", 16'hFFFF, 8'h81, 1'b0, 2'b11);
    chk("R6 lo bits", out_data, 16'hFF7E);
  endtask

  task automatic t_empty();
    for (int op = 0; op < 4; op++) begin
      one_op("R10 empty", 16'h5A5A, 8'h00, op[0], 2'(op));
      chk("R10 flag", 16'(out_flag), 16'd1);
      chk("R10 data", out_data, 16'h5A5A);
    end
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 1'b0;
    drive(16'h00F0, 8'hF0, 1'b0, 2'b00);
    @(negedge clk);
    check_out("R9 first", 16'h00F0, 8'hF0, 1'b0, 2'b00);
    drive(16'h0F00, 8'h0F, 1'b1, 2'b10);
    chk("R9 ready low", 16'(in_ready), 16'd0);
    @(negedge clk);
    check_out("R9 held", 16'h00F0, 8'hF0, 1'b0, 2'b00);
    chk("R9 still blocked", 16'(in_ready), 16'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R9 second", 16'h0F00, 8'h0F, 1'b1, 2'b10);
    @(negedge clk);
    chk("R11 drained", 16'(out_valid), 16'd0);
  endtask

  task automatic t_stream();
    logic [15:0] d[4] = '{16'h1111, 16'h8001, 16'hFFFF, 16'h7E00};
    logic [7:0]  m[4] = '{8'h11, 8'h80, 8'h3C, 8'h7E};
    logic        h[4] = '{1'b0, 1'b1, 1'b0, 1'b1};
    logic [1:0]  o[4] = '{2'b11, 2'b01, 2'b10, 2'b00};
    out_ready = 1'b1;
    for (int k = 0; k <= 4; k++) begin
      @(negedge clk);
      if (k > 0) check_out("R11 stream", d[k-1], m[k-1], h[k-1], o[k-1]);
      if (k < 4) drive(d[k], m[k], h[k], o[k]);
      else in_valid = 1'b0;
    end
  endtask

  initial begin
    t_reset();
    t_tests();
    t_modify();
    t_half();
    t_empty();
    t_stall();
    t_stream();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule